// File: doc/BRIEF.md
# Codeword Parity Checker and Sync Header Rebuilder

This receive-side block takes a stream of 2112-bit error-protected codewords. They arrive as 16-bit groups, and the first group accepted after reset starts a codeword. Each codeword holds thirty-two 65-bit segments followed by 32 check bits. Each segment is one transcode bit followed by a 64-bit payload word. The block removes the pseudo-noise scrambling and divides the descrambled codeword by the 32-bit generator polynomial to decide whether the parity holds. It also packs the segments into a two-bank buffer.

Once the final group of a codeword has been accepted, the block raises a one-cycle status strobe carrying the parity verdict. It then plays out the 32 stored segments as full 66-bit blocks, one per cycle. Each block's 2-bit sync header is rebuilt from its transcode bit. When the error-reporting configuration flag is set and the codeword failed, the header is forced to an illegal value so that the downstream decoder discards the blocks. While one bank is being played out, the other bank fills with the next codeword.

Top module: `fec_cw_checker`

## Requirements
- R1: Codeword bit k (bit 0 of each input group is received first) is XORed with pseudo-noise bit k. Each pseudo-noise bit is s[57]^s[38] of a 58-bit state s. After each bit, s shifts left and takes that pseudo-noise bit into s[0]. The state restarts at every codeword with s[i]=1 for odd i and 0 for even i.
- R2: The descrambled codeword, first bit at the highest degree, is divided by x^32+x^23+x^21+x^11+x^2+1. `chk_good` is 1 exactly when the remainder is zero. It is valid while `chk_strobe` is high, and `chk_strobe` is high for the cycle after the clock edge that accepts the codeword's last group.
- R3: Each codeword yields exactly 32 output blocks, and the 32 check bits are never forwarded. `out_valid` is high for 32 consecutive cycles, starting the cycle after `chk_strobe`.
- R4: Segment b occupies codeword bits 65b to 65b+64. Its first bit is the transcode bit T, and `out_payload[j]` is codeword bit 65b+1+j. Block b is output b-th, with header 2'b10 when T=1 and 2'b01 when T=0.
- R5: With `cfg_err_report`=1 and a failed parity check, all 32 blocks of that codeword carry header 2'b00, and their payloads are still the descrambled bits.
- R6: With `cfg_err_report`=0, headers follow R4 whatever the parity verdict.
- R7: Header 2'b11 is never emitted.
- R8: Cycles with `in_valid`=0 are ignored: their data has no effect, and codeword boundaries count only accepted groups.
- R9: A codeword may start in the cycle right after the previous one ends. Its reception overlaps the output of the previous codeword, and neither is corrupted.
- R10: During and after reset, with no input, `out_valid` and `chk_strobe` are 0.
- R11: `chk_strobe` pulses for exactly one cycle per codeword.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_err_report | input | 1 | Force header 00 on blocks of failed codewords |
| in_valid | input | 1 | Input group qualifier |
| in_data | input | 16 | Received scrambled group, bit 0 first |
| out_valid | output | 1 | Output block qualifier |
| out_hdr | output | 2 | Rebuilt sync header |
| out_payload | output | 64 | Descrambled payload word |
| chk_strobe | output | 1 | One-cycle codeword-end strobe |
| chk_good | output | 1 | Parity verdict, valid with the strobe |

## Verification
The embedded assertions watch several timing and header rules on every cycle. They check that 11 never appears, that a status strobe is always followed by output and never lasts two cycles, and that headers stay legal when reporting is off. They also check that the segment packer sits empty at each codeword boundary, and that a new codeword never arrives while the previous one is still being played out. Only the bench scenarios can show that the descrambling and the remainder are right, and that payload bits land in their proper positions. The same holds for forcing header 00 on failed codewords, ignoring idle cycles and keeping back-to-back codewords apart. For these the bench compares outputs against its own reference codewords, which carry computed check bits and injected bit errors.

// File: rtl/fec_chk_pkg.sv
package fec_chk_pkg;
  localparam int unsigned PN_LEN   = 58;
  localparam int unsigned PN_TAP   = 39;
  localparam int unsigned SYN_W    = 32;
  localparam logic [31:0] SYN_POLY = 32'h00A0_0805;

  typedef enum logic [1:0] {
    HDR_DETECT  = 2'b00,
    HDR_T_ZERO  = 2'b01,
    HDR_T_ONE   = 2'b10,
    HDR_DECFAIL = 2'b11
  } fec_hdr_e;

  function automatic logic [PN_LEN-1:0] pn_seed();
    logic [PN_LEN-1:0] r;
    for (int i = 0; i < PN_LEN; i++) r[i] = (i % 2 == 1);
    return r;
  endfunction
endpackage

// File: rtl/fec_pn_descrambler.sv
module fec_pn_descrambler
  import fec_chk_pkg::*;
#(
  parameter int unsigned GW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          restart,
  input  logic [GW-1:0] din,
  output logic [GW-1:0] dout
);
  logic [PN_LEN-1:0] st_q, st_n;

  always_comb begin
    logic [PN_LEN-1:0] s;
    logic              p;
    s    = restart ? pn_seed() : st_q;
    dout = '0;
    for (int i = 0; i < GW; i++) begin
      p       = s[PN_LEN-1] ^ s[PN_TAP-1];
      dout[i] = din[i] ^ p;
      s       = {s[PN_LEN-2:0], p};
    end
    st_n = s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  st_q <= '0;
    else if (en) st_q <= st_n;
  end
endmodule

// File: rtl/fec_syndrome.sv
module fec_syndrome
  import fec_chk_pkg::*;
#(
  parameter int unsigned GW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             restart,
  input  logic [GW-1:0]    din,
  output logic [SYN_W-1:0] syn_next
);
  logic [SYN_W-1:0] syn_q;

  always_comb begin
    logic [SYN_W-1:0] r;
    logic             msb;
    r = restart ? '0 : syn_q;
    for (int i = 0; i < GW; i++) begin
      msb = r[SYN_W-1];
      r   = {r[SYN_W-2:0], din[i]};
      if (msb) r = r ^ SYN_POLY;
    end
    syn_next = r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  syn_q <= '0;
    else if (en) syn_q <= syn_next;
  end
endmodule

// File: rtl/fec_block_packer.sv
module fec_block_packer #(
  parameter int unsigned GW    = 16,
  parameter int unsigned BLK_W = 65
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             cw_first,
  input  logic [GW-1:0]    din,
  output logic             blk_we,
  output logic [BLK_W-1:0] blk_data
);
  localparam int unsigned FILL_W = $clog2(BLK_W);

  logic [BLK_W-1:0]  acc_q, acc_n;
  logic [FILL_W-1:0] fill_q, fill_n;

  always_comb begin
    acc_n    = acc_q;
    fill_n   = fill_q;
    blk_we   = 1'b0;
    blk_data = '0;
    if (en) begin
      for (int i = 0; i < GW; i++) begin
        acc_n[fill_n] = din[i];
        if (fill_n == FILL_W'(BLK_W-1)) begin
          blk_we   = 1'b1;
          blk_data = acc_n;
          acc_n    = '0;
          fill_n   = '0;
        end else begin
          fill_n = fill_n + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      fill_q <= '0;
    end else if (en) begin
      acc_q  <= acc_n;
      fill_q <= fill_n;
    end
  end

  // segment boundaries coincide with codeword starts
  assert_pack_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cw_first) |-> (fill_q == '0));
endmodule

// File: rtl/fec_cw_buffer.sv
module fec_cw_buffer
  import fec_chk_pkg::*;
#(
  parameter int unsigned BLK_W = 65,
  parameter int unsigned NBLK  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_bank,
  input  logic [BLK_W-1:0] wr_data,
  input  logic             start,
  input  logic             start_bank,
  input  logic             start_good,
  input  logic             cfg_err_report,
  output logic             out_valid,
  output logic [1:0]       out_hdr,
  output logic [BLK_W-2:0] out_payload
);
  localparam int unsigned IDX_W = $clog2(NBLK);
  localparam int unsigned DEPTH = 2 * NBLK;

  logic [BLK_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0] wr_idx_q, wr_idx_n;
  logic             rd_act_q, rd_act_n;
  logic [IDX_W-1:0] rd_idx_q, rd_idx_n;
  logic             rd_bank_q, rd_bank_n;
  logic             rd_good_q, rd_good_n;
  logic [BLK_W-1:0] rd_word;
  logic [1:0]       hdr_n;

  always_comb begin
    wr_idx_n = wr_idx_q;
    if (wr_en) wr_idx_n = (wr_idx_q == IDX_W'(NBLK-1)) ? '0 : wr_idx_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[{wr_bank, wr_idx_q}] <= wr_data;
  end

  always_comb begin
    rd_act_n  = rd_act_q;
    rd_idx_n  = rd_idx_q;
    rd_bank_n = rd_bank_q;
    rd_good_n = rd_good_q;
    if (start) begin
      rd_act_n  = 1'b1;
      rd_idx_n  = '0;
      rd_bank_n = start_bank;
      rd_good_n = start_good;
    end else if (rd_act_q) begin
      if (rd_idx_q == IDX_W'(NBLK-1)) rd_act_n = 1'b0;
      else                            rd_idx_n = rd_idx_q + 1'b1;
    end
  end

  always_comb begin
    rd_word = mem[{rd_bank_q, rd_idx_q}];
    if (!rd_good_q && cfg_err_report) hdr_n = HDR_DETECT;
    else if (rd_word[0])              hdr_n = HDR_T_ONE;
    else                              hdr_n = HDR_T_ZERO;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_idx_q    <= '0;
      rd_act_q    <= 1'b0;
      rd_idx_q    <= '0;
      rd_bank_q   <= 1'b0;
      rd_good_q   <= 1'b0;
      out_valid   <= 1'b0;
      out_hdr     <= '0;
      out_payload <= '0;
    end else begin
      wr_idx_q  <= wr_idx_n;
      rd_act_q  <= rd_act_n;
      rd_idx_q  <= rd_idx_n;
      rd_bank_q <= rd_bank_n;
      rd_good_q <= rd_good_n;
      out_valid <= rd_act_q;
      if (rd_act_q) begin
        out_hdr     <= hdr_n;
        out_payload <= rd_word[BLK_W-1:1];
      end
    end
  end

  // a new codeword must never land while the other bank is still playing
  assert_no_overrun_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !rd_act_q);
endmodule

// File: rtl/fec_cw_checker.sv
module fec_cw_checker
  import fec_chk_pkg::*;
#(
  parameter int unsigned GROUP_W = 16,
  parameter int unsigned NBLK    = 32,
  parameter int unsigned PAY_W   = 64,
  parameter int unsigned PAR_W   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_err_report,
  input  logic               in_valid,
  input  logic [GROUP_W-1:0] in_data,
  output logic               out_valid,
  output logic [1:0]         out_hdr,
  output logic [PAY_W-1:0]   out_payload,
  output logic               chk_strobe,
  output logic               chk_good
);
  localparam int unsigned BLK_W       = PAY_W + 1;
  localparam int unsigned DATA_BITS   = NBLK * BLK_W;
  localparam int unsigned CW_BITS     = DATA_BITS + PAR_W;
  localparam int unsigned DATA_GROUPS = DATA_BITS / GROUP_W;
  localparam int unsigned CW_GROUPS   = CW_BITS / GROUP_W;
  localparam int unsigned GCW         = $clog2(CW_GROUPS);

  logic [GCW-1:0]     grp_q, grp_n;
  logic               cw_first, cw_last, in_data_region;
  logic [GROUP_W-1:0] clear_data;
  logic [SYN_W-1:0]   syn_next;
  logic               blk_we;
  logic [BLK_W-1:0]   blk_data;
  logic               bank_q, bank_n;
  logic               stb_n, good_n;

  assign cw_first       = (grp_q == '0);
  assign cw_last        = (grp_q == GCW'(CW_GROUPS-1));
  assign in_data_region = (grp_q < GCW'(DATA_GROUPS));

  fec_pn_descrambler #(.GW(GROUP_W)) u_descr (
    .clk(clk), .rst_n(rst_n), .en(in_valid), .restart(cw_first),
    .din(in_data), .dout(clear_data)
  );

  fec_syndrome #(.GW(GROUP_W)) u_syn (
    .clk(clk), .rst_n(rst_n), .en(in_valid), .restart(cw_first),
    .din(clear_data), .syn_next(syn_next)
  );

  fec_block_packer #(.GW(GROUP_W), .BLK_W(BLK_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .en(in_valid && in_data_region),
    .cw_first(cw_first), .din(clear_data),
    .blk_we(blk_we), .blk_data(blk_data)
  );

  always_comb begin
    grp_n  = grp_q;
    bank_n = bank_q;
    stb_n  = in_valid && cw_last;
    good_n = (syn_next == '0);
    if (in_valid) begin
      grp_n = cw_last ? '0 : grp_q + 1'b1;
      if (cw_last) bank_n = ~bank_q;
    end
  end

  fec_cw_buffer #(.BLK_W(BLK_W), .NBLK(NBLK)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .wr_en(blk_we), .wr_bank(bank_q), .wr_data(blk_data),
    .start(stb_n), .start_bank(bank_q), .start_good(good_n),
    .cfg_err_report(cfg_err_report),
    .out_valid(out_valid), .out_hdr(out_hdr), .out_payload(out_payload)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_q      <= '0;
      bank_q     <= 1'b0;
      chk_strobe <= 1'b0;
      chk_good   <= 1'b0;
    end else begin
      grp_q      <= grp_n;
      bank_q     <= bank_n;
      chk_strobe <= stb_n;
      if (stb_n) chk_good <= good_n;
    end
  end

  assert_no_decfail_hdr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_hdr != HDR_DECFAIL));

  assert_emit_follows_check_R3: assert property (@(posedge clk) disable iff (!rst_n)
    chk_strobe |=> out_valid);

  assert_strobe_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    chk_strobe |=> !chk_strobe);

  assert_plain_hdr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !cfg_err_report) |-> (out_hdr[1] ^ out_hdr[0]));
endmodule

// File: tb/fec_cw_checker_tb.sv
`timescale 1ns/1ps
module fec_cw_checker_tb;
  localparam int DBITS  = 2080;
  localparam int CWBITS = 2112;
  localparam int NGRP   = 132;
  localparam int NBLK   = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic        out_valid, chk_strobe, chk_good;
  logic [1:0]  out_hdr;
  logic [63:0] out_payload;

  fec_cw_checker u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_err_report(cfg),
    .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_hdr(out_hdr), .out_payload(out_payload),
    .chk_strobe(chk_strobe), .chk_good(chk_good)
  );

  always #2 clk = ~clk;

  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_run = 0, n_fail = 0;

  logic [1:0]  obs_hdr [0:511];
  logic [63:0] obs_pay [0:511];
  longint      obs_cyc [0:511];
  int          obs_n = 0;
  logic        stb_good [0:31];
  longint      stb_cyc  [0:31];
  int          stb_n = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid && obs_n < 512) begin
        obs_hdr[obs_n] = out_hdr;
        obs_pay[obs_n] = out_payload;
        obs_cyc[obs_n] = cyc;
        obs_n = obs_n + 1;
      end
      if (chk_strobe && stb_n < 32) begin
        stb_good[stb_n] = chk_good;
        stb_cyc[stb_n]  = cyc;
        stb_n = stb_n + 1;
      end
    end
  end

  logic   cwb [0:1][0:CWBITS-1];
  longint last_edge;

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // tmode: 0 random T, 1 all zero, 2 all one
  task automatic build(input int slot, input int tmode, input int flip_pos, input int flip_len);
    logic [31:0] r;
    logic        b, msb;
    for (int i = 0; i < DBITS; i++) begin
      if (i % 65 == 0) cwb[slot][i] = (tmode == 0) ? 1'($urandom % 2) : (tmode == 2);
      else             cwb[slot][i] = 1'($urandom % 2);
    end
    r = '0;
    for (int i = 0; i < CWBITS; i++) begin
      b   = (i < DBITS) ? cwb[slot][i] : 1'b0;
      msb = r[31];
      r   = {r[30:0], b};
      if (msb) r = r ^ 32'h00A00805;
    end
    for (int k = 0; k < 32; k++) cwb[slot][DBITS+k] = r[31-k];
    for (int k = 0; k < flip_len; k++) cwb[slot][flip_pos+k] = ~cwb[slot][flip_pos+k];
  endtask

  task automatic send(input int slot, input int gap);
    logic [57:0] s;
    logic [15:0] w;
    logic        p;
    for (int i = 0; i < 58; i++) s[i] = (i % 2 == 1);
    for (int g = 0; g < NGRP; g++) begin
      @(negedge clk);
      for (int j = 0; j < 16; j++) begin
        p    = s[57] ^ s[38];
        w[j] = cwb[slot][16*g+j] ^ p;
        s    = {s[56:0], p};
      end
      in_data  = w;
      in_valid = 1'b1;
      if (gap > 0 && (g % gap) == gap - 1 && g != NGRP - 1) begin
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = 16'($urandom);
      end
    end
    @(posedge clk);
    #1 last_edge = cyc;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = '0;
    repeat (n) @(negedge clk);
  endtask

  task automatic verify(input int slot, input int ob, input int sb, input bit exp_good,
                        input longint edge_c, input string tag);
    logic [63:0] ep;
    logic [1:0]  eh;
    string       hreq;
    check(stb_n > sb, {tag, " R11 strobe seen"}, stb_n, sb + 1);
    check(stb_good[sb] == exp_good, {tag, " R2 verdict"}, stb_good[sb], exp_good);
    check(stb_cyc[sb] == edge_c, {tag, " R2 strobe cycle"}, stb_cyc[sb], edge_c);
    check(obs_n >= ob + NBLK, {tag, " R3 block count"}, obs_n - ob, NBLK);
    check(obs_cyc[ob] == edge_c + 1, {tag, " R3 first block cycle"}, obs_cyc[ob], edge_c + 1);
    check(obs_cyc[ob+NBLK-1] == edge_c + NBLK, {tag, " R3 last block cycle"},
          obs_cyc[ob+NBLK-1], edge_c + NBLK);
    for (int b = 0; b < NBLK; b++) begin
      for (int j = 0; j < 64; j++) ep[j] = cwb[slot][65*b+1+j];
      if (!exp_good && cfg) begin eh = 2'b00; hreq = " R5 header"; end
      else begin
        eh   = cwb[slot][65*b] ? 2'b10 : 2'b01;
        hreq = exp_good ? " R4 header" : " R6 header";
      end
      check(obs_hdr[ob+b] == eh, {tag, hreq}, obs_hdr[ob+b], eh);
      check(obs_hdr[ob+b] != 2'b11, {tag, " R7 no 11"}, obs_hdr[ob+b], 2'b01);
      check(obs_pay[ob+b] == ep, {tag, " R1 R4 payload"}, obs_pay[ob+b], ep);
    end
  endtask

  task automatic run_one(input string tag, input bit rep, input int tmode,
                         input int fpos, input int flen, input int gap);
    int ob, sb;
    cfg = rep;
    ob  = obs_n;
    sb  = stb_n;
    build(0, tmode, fpos, flen);
    send(0, gap);
    idle(40);
    check(stb_n == sb + 1, {tag, " R11 one strobe"}, stb_n - sb, 1);
    verify(0, ob, sb, flen == 0, last_edge, tag);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(!out_valid && !chk_strobe, "R10 in reset", {out_valid, chk_strobe}, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check(!out_valid && !chk_strobe && obs_n == 0, "R10 after reset",
          {out_valid, chk_strobe}, 0);
  endtask

  task automatic t_back_to_back();
    int     ob, sb;
    longint ea;
    cfg = 1'b1;
    ob  = obs_n;
    sb  = stb_n;
    build(0, 0, 0, 0);
    build(1, 0, 700, 5);
    send(0, 0);
    ea = last_edge;
    send(1, 0);
    idle(40);
    check(stb_n == sb + 2, "R9 two strobes", stb_n - sb, 2);
    verify(0, ob, sb, 1'b1, ea, "b2b first");
    verify(1, ob + NBLK, sb + 1, 1'b0, last_edge, "b2b second R9");
  endtask

  initial begin
    t_reset();
    run_one("good mixed T",       1'b1, 0, 0,    0,  0);
    run_one("good T zero",        1'b1, 1, 0,    0,  0);
    run_one("good T one",         1'b0, 2, 0,    0,  0);
    run_one("bad single report",  1'b1, 0, 333,  1,  0);
    run_one("bad burst noreport", 1'b0, 0, 1500, 12, 0);
    run_one("bad parity report",  1'b1, 2, 2090, 3,  0);
    run_one("gaps R8 good",       1'b1, 0, 0,    0,  5);
    run_one("gaps R8 bad",        1'b1, 0, 65,   1,  3);
    t_back_to_back();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule